// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Slave

This block lets an external host reach a small bank of registers over one byte-wide bus that carries the address and then the data. The host puts a register address on the shared lines and pulses the address latch enable high. The block keeps that address after the host takes it off the bus. The host then lowers chip select together with either the read strobe or the write strobe. During a read the block drives the addressed register onto the shared lines. During a write it takes the byte from the lines and stores it when the write strobe goes back high.

Every bus input passes through a two-stage synchroniser into the local clock domain before any logic uses it. The bank holds a set of read/write control registers at the bottom of the address space, whose contents appear on a flat output vector. It also holds a set of read-only status bytes, taken live from input pins, at a fixed base address. The tristate pad sits outside the block and is driven from separate data-out, output-enable and data-in ports.

Top module: `mux_bus_slave`

## Requirements
- R1: When rst_ni is low, every control register and the latched address are cleared to zero. A read after reset that has no address phase therefore returns control register 0, whose value is 0x00.
- R2: The address is the value that was on ad_i while ale_i was high, taken when ale_i falls. It stays in use for every later read or write until the next fall of ale_i, whatever ad_i does in the meantime.
- R3: A write stores the byte present on ad_i while wr_ni was low. It is committed once, when the synchronised wr_ni rises with cs_ni low. A long write strobe, or a change on ad_i after the strobe has ended, produces no second write.
- R4: A write strobe given while cs_ni is high changes no register.
- R5: ad_oe_o is high only while the synchronised cs_ni and rd_ni are both low. While it is high, ad_o carries the addressed register. It goes low again once either strobe has returned high.
- R6: A read from an address that holds no register returns 0x00. Control registers sit at addresses 0x00 to 0x03 and status bytes at 0x10 and 0x11.
- R7: Writes to the status addresses or to an unused address change no control register, and a status byte still reads its input afterwards.
- R8: If rd_ni and wr_ni are low together with cs_ni low, the cycle acts as a read and no register is written.
- R9: Status address 0x10 returns status_i[7:0] and address 0x11 returns status_i[15:8], with the value the pins have at the time of the read.
- R10: ad_oe_o stays low while the bus is idle and throughout a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 8 | Shared address/data lines as seen from the pad |
| ad_o | output | 8 | Read data to the pad driver |
| ad_oe_o | output | 1 | Pad output enable, high while a read is active |
| ale_i | input | 1 | Address latch enable, active high |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| status_i | input | 16 | Read-only status bytes, lowest byte at 0x10 |
| ctrl_o | output | 32 | Control registers, register 0 in bits 7:0 |

## Verification
The bench keeps the address phase off the bus and then runs several reads in a row. A design that samples ad_i during the data phase instead of keeping the latched address returns the wrong register. It holds a write strobe low for many cycles and changes the bus once the strobe has ended. A level-triggered write would store the later value or write more than once. It lowers both strobes together, strobes with chip select high, and writes to status and unused addresses. A design that lets any of these through changes a control register that the bench checks on ctrl_o. Reads from unused addresses and live status changes catch a read mux that passes through stale data or decodes the wrong address.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int unsigned DATA_W = 8;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic  ale;
    logic  cs_n;
    logic  rd_n;
    logic  wr_n;
    byte_t ad;
  } bus_t;

  localparam int unsigned BUS_W = $bits(bus_t);
  localparam bus_t BUS_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ad: '0};
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  bus_t  bus_i,
  output byte_t addr_o,
  output logic  we_o,
  output byte_t wdata_o,
  output logic  rd_active_o
);
  logic  ale_d, wr_d, clash_q;
  byte_t addr_shadow_q, addr_q, wdata_q;
  logic  ale_fall, wr_rise;

  assign ale_fall = ale_d && !bus_i.ale;
  assign wr_rise  = !wr_d && bus_i.wr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_d         <= 1'b0;
      wr_d          <= 1'b1;
      clash_q       <= 1'b0;
      addr_shadow_q <= '0;
      addr_q        <= '0;
      wdata_q       <= '0;
    end else begin
      ale_d <= bus_i.ale;
      wr_d  <= bus_i.wr_n;
      if (bus_i.ale) addr_shadow_q <= bus_i.ad;
      if (ale_fall)  addr_q        <= addr_shadow_q;
      if (!bus_i.wr_n) wdata_q <= bus_i.ad;
      // remember a read strobe seen at any time during the write pulse
      if (!bus_i.wr_n && !bus_i.rd_n) clash_q <= 1'b1;
      else if (bus_i.wr_n)            clash_q <= 1'b0;
    end
  end

  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign we_o        = wr_rise && !bus_i.cs_n && bus_i.rd_n && !clash_q;
  assign rd_active_o = !bus_i.cs_n && !bus_i.rd_n;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_fall |=> $stable(addr_q));

  p_single_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import mux_bus_pkg::*;
#(
  parameter int unsigned NUM_CTRL  = 4,
  parameter int unsigned NUM_STAT  = 2,
  parameter byte_t       STAT_BASE = 8'h10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  byte_t                      addr_i,
  input  byte_t                      wdata_i,
  input  logic [NUM_STAT*DATA_W-1:0] status_i,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  output byte_t                      rdata_o
);
  logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ctrl_q[i] <= '0;
      else if (we_i && addr_i == byte_t'(i))    ctrl_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr_i == byte_t'(i)) rdata_o = ctrl_q[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (addr_i == STAT_BASE + byte_t'(j)) rdata_o = status_i[j*DATA_W +: DATA_W];
  end

  assign ctrl_o = ctrl_q;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (ctrl_q == '0));

  p_ro_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i >= byte_t'(NUM_CTRL))) |=> $stable(ctrl_q));
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mux_bus_pkg::*;
#(
  parameter int unsigned NUM_CTRL    = 4,
  parameter int unsigned NUM_STAT    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  STAT_BASE   = 8'h10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 ad_i,
  output logic [7:0]                 ad_o,
  output logic                       ad_oe_o,
  input  logic                       ale_i,
  input  logic                       cs_ni,
  input  logic                       rd_ni,
  input  logic                       wr_ni,
  input  logic [NUM_STAT*8-1:0]      status_i,
  output logic [NUM_CTRL*8-1:0]      ctrl_o
);
  bus_t  bus_raw, bus_s;
  byte_t addr, wdata, rdata;
  logic  we, rd_active;

  assign bus_raw = '{ale: ale_i, cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni, ad: ad_i};

  bus_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  bus_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_i      (bus_s),
    .addr_o     (addr),
    .we_o       (we),
    .wdata_o    (wdata),
    .rd_active_o(rd_active)
  );

  reg_bank #(
    .NUM_CTRL (NUM_CTRL),
    .NUM_STAT (NUM_STAT),
    .STAT_BASE(STAT_BASE)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .status_i(status_i),
    .ctrl_o  (ctrl_o),
    .rdata_o (rdata)
  );

  assign ad_oe_o = rd_active;
  assign ad_o    = rd_active ? rdata : '0;

  p_oe_read_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (!$past(cs_ni, 2) && !$past(rd_ni, 2)));

  p_no_write_on_clash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rd_ni, 2) && !$past(wr_ni, 2)) |-> !we);
endmodule

// File: tb/mux_bus_slave_tb.sv
module mux_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic        ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] status = 16'h0000;
  logic [31:0] ctrl;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ctrl [4];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  mux_bus_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .ale_i(ale), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .status_i(status), .ctrl_o(ctrl)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] model_read(logic [7:0] a);
    if (a < 8'd4)   return exp_ctrl[a[1:0]];
    if (a == 8'h10) return status[7:0];
    if (a == 8'h11) return status[15:8];
    return 8'h00;
  endfunction

  function automatic logic [31:0] model_ctrl();
    return {exp_ctrl[3], exp_ctrl[2], exp_ctrl[1], exp_ctrl[0]};
  endfunction

  task automatic addr_phase(logic [7:0] a);
    ad_i = a; ale = 1'b1; tick(3);
    ale = 1'b0; tick(3);
    ad_i = ~a;
  endtask

  task automatic read_data(logic [7:0] a, string req);
    exp_q.push_back(model_read(a));
    tag_q.push_back(req);
    cs_n = 1'b0; rd_n = 1'b0; tick(5);
    rd_n = 1'b1; cs_n = 1'b1; tick(4);
    check("R5", {31'd0, ad_oe}, 32'd0);
  endtask

  task automatic bus_read(logic [7:0] a, string req);
    addr_phase(a);
    read_data(a, req);
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d, bit sel, bit rd_too, int hold);
    addr_phase(a);
    if (rd_too) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back("R8");
    end
    ad_i = d; cs_n = !sel; wr_n = 1'b0; rd_n = !rd_too;
    tick(hold);
    if (!rd_too) check("R10", {31'd0, ad_oe}, 32'd0);
    wr_n = 1'b1; rd_n = 1'b1; tick(4);
    ad_i = 8'h5A; tick(3);
    cs_n = 1'b1; tick(3);
    if (sel && !rd_too && a < 8'd4) exp_ctrl[a[1:0]] = d;
  endtask

  // monitor: one expected byte per read pulse
  initial begin
    forever begin
      @(posedge ad_oe);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: actual %h expected no read", ad_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, ad_o}, {24'd0, e});
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_ctrl[i] = 8'h00;
    tick(4);
    check("R1", ctrl, 32'h0);
    check("R10", {31'd0, ad_oe}, 32'd0);
    rst_n = 1'b1; tick(3);
    check("R1", ctrl, 32'h0);
    read_data(8'h00, "R1");

    bus_write(8'h00, 8'h11, 1, 0, 3);
    bus_write(8'h01, 8'hA2, 1, 0, 3);
    bus_write(8'h02, 8'h3C, 1, 0, 3);
    bus_write(8'h03, 8'hF4, 1, 0, 3);
    check("R3", ctrl, model_ctrl());
    for (int i = 0; i < 4; i++) bus_read(8'(i), "R5");

    addr_phase(8'h02);
    ad_i = 8'h01;
    read_data(8'h02, "R2");
    ad_i = 8'hFF;
    read_data(8'h02, "R2");

    bus_write(8'h01, 8'h77, 0, 0, 3);
    check("R4", ctrl, model_ctrl());
    bus_read(8'h01, "R4");

    bus_read(8'h07, "R6");
    bus_read(8'hFF, "R6");
    bus_read(8'h04, "R6");

    status = 16'hC33C;
    bus_read(8'h10, "R9");
    bus_read(8'h11, "R9");
    status = 16'h5AA5;
    bus_read(8'h10, "R9");

    bus_write(8'h10, 8'h99, 1, 0, 3);
    bus_write(8'h20, 8'h98, 1, 0, 3);
    check("R7", ctrl, model_ctrl());
    bus_read(8'h10, "R7");

    bus_write(8'h00, 8'hEE, 1, 1, 5);
    check("R8", ctrl, model_ctrl());

    bus_write(8'h03, 8'h42, 1, 0, 12);
    check("R3", ctrl, model_ctrl());
    addr_phase(8'h03);
    cs_n = 1'b0; ad_i = 8'h24; tick(6);
    cs_n = 1'b1; tick(3);
    check("R3", ctrl, model_ctrl());
    read_data(8'h03, "R3");

    tick(4);
    check("R5", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule